// File: doc/BRIEF.md
# Programmable Interval Countdown Timer

This block is an 8-bit presettable binary down-counter that raises an interrupt when it runs out. Four tick strobes enter the block: 4096 Hz, 64 Hz, a once-per-second update and a once-per-minute update. A 2-bit select picks one of them, and each selected strobe takes one off the count. While the enable is low the counter holds the preset and does not count. Counting always restarts from the preset; there is no pause and resume.

When the count runs out, a sticky flag is set. Software clears the flag with a clear strobe and can never set it. The interrupt drive is an open-drain style output, modelled as a pull-low enable. There are two modes:
- In level mode the counter stops at zero and the drive stays on for as long as the flag is set.
- In repeat mode the counter reloads the preset and keeps going. The drive then becomes a fixed pulse of 16 periods of the 4096 Hz strobe (about 3.9 ms), while the flag stays set.

The interrupt enable gates the drive only. A preset of zero never produces an interrupt.

Top module: `ivt_timer`

## Requirements
- R1: While enabled, each strobe of the selected source lowers a count above 1 by exactly one, visible on `count` one cycle after the strobe.
- R2: `src_sel` picks the tick source: 00 = `tick_4k`, 01 = `tick_64`, 10 = `tick_sec`, 11 = `tick_min`. Strobes on the other three inputs do not change `count`.
- R3: While `tmr_en` is 0, `count` takes the value of `preset` every cycle and ignores all strobes. After `tmr_en` rises, counting starts from that preset.
- R4: A selected strobe while `count` is 1 is an expiry. The cycle after it, `flag` reads 1.
- R5: In repeat mode (`repeat_mode` = 1), an expiry loads `preset` into `count` and counting continues.
- R6: In repeat mode, an expiry turns on `irq_pull` for the next 16 strobes of `tick_4k`, provided `irq_en` is 1, and then turns it off. `flag` stays 1 until it is cleared.
- R7: In level mode (`repeat_mode` = 0), an expiry leaves `count` at 0 and counting stops. `irq_pull` equals `flag` while `irq_en` is 1.
- R8: While `irq_en` is 0, `irq_pull` is 0.
- R9: With a preset of 0, `flag` never rises and `count` stays 0.
- R10: A `flag_clr` strobe clears `flag` on the next cycle, unless an expiry happens in the same cycle (the expiry wins). No input other than an expiry sets `flag`.
- R11: After reset, `count`, `flag` and `irq_pull` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_4k | input | 1 | One-cycle strobe at 4096 Hz; also times the repeat pulse |
| tick_64 | input | 1 | One-cycle strobe at 64 Hz |
| tick_sec | input | 1 | One-cycle per-second update strobe |
| tick_min | input | 1 | One-cycle per-minute update strobe |
| src_sel | input | 2 | Tick source select |
| preset | input | 8 | Preset / reload value |
| tmr_en | input | 1 | Timer enable |
| repeat_mode | input | 1 | 1 = repeat with pulse, 0 = level |
| irq_en | input | 1 | Interrupt drive enable |
| flag_clr | input | 1 | Strobe that writes 0 to the flag |
| count | output | 8 | Current counter value |
| flag | output | 1 | Sticky timer flag |
| irq_pull | output | 1 | 1 = pull the interrupt line low |

## Verification
`count` and `flag` move on the clock edge that samples a strobe, so their new value is due one cycle after the strobe. `irq_pull` follows from the registered flag and pulse state through logic that also depends on the current `irq_en` and `repeat_mode`. It is therefore due in the same cycle as the state it reflects. The driver changes inputs on the falling edge. At each rising edge it pushes the expected count, flag and drive for that edge. The monitor pops that item a quarter period after the edge and compares it against the outputs, which have settled by then. This keeps every comparison on the cycle in which its result is due.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
   typedef enum logic [1:0] {
      SRC_4K  = 2'b00,
      SRC_64  = 2'b01,
      SRC_SEC = 2'b10,
      SRC_MIN = 2'b11
   } src_e;

   localparam int unsigned NUM_SRC = 4;
   localparam int unsigned SRC_SEL_W = $clog2(NUM_SRC);
endpackage

// File: rtl/ivt_tick_sel.sv
module ivt_tick_sel #(
   parameter int unsigned N_SRC = 4,
   localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic [N_SRC-1:0] ticks,
   input  logic [SEL_W-1:0] sel,
   output logic             tick_o
);
   if (N_SRC < 1) begin : g_bad_nsrc
      $error("ivt_tick_sel: N_SRC must be at least 1");
   end

   if ((1 << SEL_W) == N_SRC) begin : g_full
      // Every select code maps onto a source.
      assign tick_o = ticks[sel];
   end else begin : g_partial
      // Codes beyond the last source select nothing.
      always_comb begin
         tick_o = 1'b0;
         for (int i = 0; i < N_SRC; i++) begin
            if (sel == SEL_W'(i)) tick_o = ticks[i];
         end
      end
   end
endmodule

// File: rtl/ivt_down_cnt.sv
module ivt_down_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             reload,
   input  logic [CNT_W-1:0] preset,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   if (CNT_W < 2) begin : g_bad_w
      $error("ivt_down_cnt: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] cnt_q;
   logic             last;

   assign last   = (cnt_q == ONE);
   assign expire = en & tick & last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
      end else if (!en) begin
         cnt_q <= preset;
      end else if (tick && (cnt_q != ZERO)) begin
         if (last) cnt_q <= reload ? preset : ZERO;
         else      cnt_q <= cnt_q - ONE;
      end
   end

   assign count = cnt_q;
endmodule

// File: rtl/ivt_irq_ctl.sv
module ivt_irq_ctl #(
   parameter int unsigned PULSE_TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic repeat_mode,
   input  logic irq_en,
   input  logic flag_clr,
   input  logic pulse_tick,
   output logic flag,
   output logic irq_pull
);
   if (PULSE_TICKS < 1) begin : g_bad_pw
      $error("ivt_irq_ctl: PULSE_TICKS must be at least 1");
   end

   logic flag_q;
   logic pulse_on;

   always_ff @(posedge clk) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (expire)   flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   if (PULSE_TICKS == 1) begin : g_pulse_bit
      logic p_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                      p_q <= 1'b0;
         else if (expire && repeat_mode)  p_q <= 1'b1;
         else if (pulse_tick)             p_q <= 1'b0;
      end
      assign pulse_on = p_q;
   end else begin : g_pulse_cnt
      localparam int unsigned PW = $clog2(PULSE_TICKS + 1);
      logic [PW-1:0] p_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                            p_q <= '0;
         else if (expire && repeat_mode)        p_q <= PW'(PULSE_TICKS);
         else if (pulse_tick && (p_q != '0))    p_q <= p_q - PW'(1);
      end
      assign pulse_on = (p_q != '0);
   end

   assign flag     = flag_q;
   assign irq_pull = irq_en & (repeat_mode ? pulse_on : flag_q);
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer #(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned PULSE_TICKS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_4k,
   input  logic             tick_64,
   input  logic             tick_sec,
   input  logic             tick_min,
   input  logic [1:0]       src_sel,
   input  logic [CNT_W-1:0] preset,
   input  logic             tmr_en,
   input  logic             repeat_mode,
   input  logic             irq_en,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] count,
   output logic             flag,
   output logic             irq_pull
);
   import ivt_pkg::*;

   logic [NUM_SRC-1:0] src_vec;
   logic               tick_sel;
   logic               expire;

   always_comb begin
      src_vec          = '0;
      src_vec[SRC_4K]  = tick_4k;
      src_vec[SRC_64]  = tick_64;
      src_vec[SRC_SEC] = tick_sec;
      src_vec[SRC_MIN] = tick_min;
   end

   ivt_tick_sel #(.N_SRC(NUM_SRC)) u_sel (
      .ticks (src_vec),
      .sel   (src_sel),
      .tick_o(tick_sel)
   );

   ivt_down_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (tmr_en),
      .tick  (tick_sel),
      .reload(repeat_mode),
      .preset(preset),
      .count (count),
      .expire(expire)
   );

   ivt_irq_ctl #(.PULSE_TICKS(PULSE_TICKS)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .expire     (expire),
      .repeat_mode(repeat_mode),
      .irq_en     (irq_en),
      .flag_clr   (flag_clr),
      .pulse_tick (tick_4k),
      .flag       (flag),
      .irq_pull   (irq_pull)
   );
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_4k,
   input logic             tick_64,
   input logic             tick_sec,
   input logic             tick_min,
   input logic [1:0]       src_sel,
   input logic [CNT_W-1:0] preset,
   input logic             tmr_en,
   input logic             repeat_mode,
   input logic             irq_en,
   input logic             flag_clr,
   input logic [CNT_W-1:0] count,
   input logic             flag,
   input logic             irq_pull
);
   logic t_sel;
   logic exp_c;

   always_comb begin
      case (src_sel)
         2'b00:   t_sel = tick_4k;
         2'b01:   t_sel = tick_64;
         2'b10:   t_sel = tick_sec;
         default: t_sel = tick_min;
      endcase
   end
   assign exp_c = tmr_en && t_sel && (count == CNT_W'(1));

   a_r3_hold_preset: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_en |=> count == $past(preset));
   a_r1_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_en && t_sel && count > CNT_W'(1)) |=> count == $past(count) - CNT_W'(1));
   a_r2_unselected_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_en && !t_sel) |=> count == $past(count));
   a_r4_expire_flag: assert property (@(posedge clk) disable iff (!rst_n)
      exp_c |=> flag);
   a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_c && repeat_mode) |=> count == $past(preset));
   a_r7_level_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_c && !repeat_mode) |=> count == '0);
   a_r7_level_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (!repeat_mode && irq_en) |-> irq_pull == flag);
   a_r8_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq_pull);
   a_r9_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(count) == CNT_W'(1));
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !exp_c) |=> !flag);
   a_r10_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !exp_c) |=> !flag);
   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);
endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_4k(tick_4k), .tick_64(tick_64),
   .tick_sec(tick_sec), .tick_min(tick_min), .src_sel(src_sel),
   .preset(preset), .tmr_en(tmr_en), .repeat_mode(repeat_mode),
   .irq_en(irq_en), .flag_clr(flag_clr), .count(count), .flag(flag),
   .irq_pull(irq_pull)
);

// File: tb/ivt_timer_tb.sv
module ivt_timer_tb;
   localparam int CLK_P = 10;
   localparam int PULSE = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_4k = 0, tick_64 = 0, tick_sec = 0, tick_min = 0;
   logic [1:0] src_sel = 2'b00;
   logic [7:0] preset = 8'd0;
   logic       tmr_en = 0, repeat_mode = 0, irq_en = 0, flag_clr = 0;
   logic [7:0] count;
   logic       flag, irq_pull;

   ivt_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tick_4k(tick_4k), .tick_64(tick_64),
      .tick_sec(tick_sec), .tick_min(tick_min), .src_sel(src_sel),
      .preset(preset), .tmr_en(tmr_en), .repeat_mode(repeat_mode),
      .irq_en(irq_en), .flag_clr(flag_clr), .count(count), .flag(flag),
      .irq_pull(irq_pull)
   );

   always #(CLK_P/2) clk = ~clk;

   typedef struct {
      logic [7:0] cnt;
      logic       flg;
      logic       irq;
      string      tag;
   } exp_t;

   exp_t  sb_q[$];
   int    checks = 0;
   int    failures = 0;
   bit    done = 0;
   string cur_tag = "R11";

   // reference state, built from the requirements
   int m_cnt = 0;
   bit m_flag = 0;
   int m_pulse = 0;

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // monitor: compares a quarter period after each rising edge
   always @(posedge clk) begin
      #(CLK_P/4);
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if (count !== e.cnt || flag !== e.flg || irq_pull !== e.irq) begin
            failures++;
            $display("FAIL %s: count/flag/irq actual=%0d/%0b/%0b expected=%0d/%0b/%0b",
                     e.tag, count, flag, irq_pull, e.cnt, e.flg, e.irq);
         end
      end
   end

   // driver: one clock cycle of stimulus, pushes the result due at the edge
   task automatic cyc(input bit en, input bit rep, input bit ie, input bit clr,
                      input logic [1:0] sel, input logic [7:0] pre,
                      input logic [3:0] tk);
      bit sel_tk, exp_ev;
      int n_cnt, n_pulse;
      bit n_flag;
      exp_t e;
      @(negedge clk);
      tmr_en = en; repeat_mode = rep; irq_en = ie; flag_clr = clr;
      src_sel = sel; preset = pre;
      {tick_min, tick_sec, tick_64, tick_4k} = tk;
      sel_tk = tk[sel];
      exp_ev = 0;
      n_cnt  = m_cnt;
      if (!en) n_cnt = pre;
      else if (sel_tk && m_cnt != 0) begin
         if (m_cnt == 1) begin
            exp_ev = 1;
            n_cnt  = rep ? int'(pre) : 0;
         end else n_cnt = m_cnt - 1;
      end
      n_flag  = exp_ev ? 1'b1 : (clr ? 1'b0 : m_flag);
      n_pulse = m_pulse;
      if (exp_ev && rep) n_pulse = PULSE;
      else if (tk[0] && m_pulse > 0) n_pulse = m_pulse - 1;
      @(posedge clk);
      m_cnt = n_cnt; m_flag = n_flag; m_pulse = n_pulse;
      e.cnt = 8'(m_cnt);
      e.flg = m_flag;
      e.irq = ie && (rep ? (m_pulse > 0) : m_flag);
      e.tag = cur_tag;
      sb_q.push_back(e);
   endtask

   function automatic logic [3:0] rnd_ticks();
      logic [3:0] t;
      t[0] = ($urandom % 2) == 0;
      t[1] = ($urandom % 3) == 0;
      t[2] = ($urandom % 4) == 0;
      t[3] = ($urandom % 5) == 0;
      return t;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      // R11: reset state
      repeat (3) @(negedge clk);
      preset = 8'd77;
      @(negedge clk);
      checks++;
      if (count !== 8'd0 || flag !== 1'b0 || irq_pull !== 1'b0) begin
         failures++;
         $display("FAIL R11: actual=%0d/%0b/%0b expected=0/0/0", count, flag, irq_pull);
      end
      rst_n = 1'b1;

      // R3: disabled counter follows preset, strobes ignored
      cur_tag = "R3";
      for (int i = 0; i < 20; i++)
         cyc(0, 0, 1, 0, 2'($urandom), 8'($urandom), 4'hF);

      // R1/R2: each source in turn, random strobes on all four
      for (int s = 0; s < 4; s++) begin
         cur_tag = "R1/R2";
         cyc(0, 0, 1, 1, 2'(s), 8'd200, 4'h0);
         for (int i = 0; i < 60; i++) cyc(1, 0, 1, 0, 2'(s), 8'd200, rnd_ticks());
      end

      // R3 restart from preset after re-enable
      cur_tag = "R3";
      cyc(0, 0, 1, 0, 2'd1, 8'd9, 4'hF);
      for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0, 2'd1, 8'd9, 4'h2);

      // R4/R7: level mode expiry and hold
      cur_tag = "R4/R7";
      cyc(0, 0, 1, 1, 2'd0, 8'd3, 4'h0);
      for (int i = 0; i < 14; i++) cyc(1, 0, 1, 0, 2'd0, 8'd3, 4'h1);

      // R10: clear the flag, then no input sets it
      cur_tag = "R10";
      cyc(1, 0, 1, 1, 2'd0, 8'd3, 4'hF);
      for (int i = 0; i < 6; i++) cyc(1, 0, 1, 0, 2'd0, 8'd3, 4'hF);

      // R5/R6: repeat mode, reload and fixed-width pulse, flag sticky
      cur_tag = "R5/R6";
      cyc(0, 1, 1, 1, 2'd1, 8'd6, 4'h0);
      for (int i = 0; i < 400; i++)
         cyc(1, 1, 1, 0, 2'd1, 8'd6, {2'b00, (i % 5) == 0, 1'b1});
      cur_tag = "R6";
      for (int i = 0; i < 200; i++)
         cyc(1, 1, 1, (i % 37) == 0, 2'd2, 8'd3, rnd_ticks());

      // R10: clear strobes racing expiries (expiry wins)
      cur_tag = "R10";
      cyc(0, 0, 1, 1, 2'd0, 8'd2, 4'h0);
      for (int i = 0; i < 40; i++) cyc(1, i % 2, 1, 1, 2'd0, 8'd2, 4'h1);

      // R8: interrupt enable off, both modes
      cur_tag = "R8";
      for (int i = 0; i < 80; i++)
         cyc(1, (i / 40) == 1, 0, (i % 23) == 0, 2'd0, 8'd4, rnd_ticks());

      // R9: preset of zero never interrupts
      cur_tag = "R9";
      cyc(0, 0, 1, 1, 2'd0, 8'd0, 4'h0);
      for (int i = 0; i < 60; i++) cyc(1, i >= 30, 1, 0, 2'(i % 4), 8'd0, 4'hF);

      repeat (3) @(posedge clk);
      #(CLK_P/2);
      finish_run();
   end
endmodule